// File: doc/BRIEF.md
# Line Period and Average Estimator

This block takes a stream of rectified line-voltage samples, each an unsigned Q15 magnitude delivered with a one-cycle strobe. It marks the start of each line half-cycle when the signal rises through a high threshold. A low threshold must be passed again before the next rise can count, so ripple near the top of the wave cannot start a false period. Between two accepted rises it counts the samples taken (N) and adds them up.

At each accepted rise the block starts a bit-serial divider that produces two results. The first is the per-unit frequency `n_min / N` in Q15, where `n_min` is the sample count of the shortest allowed period. The second is the period mean scaled by pi/2, so that the largest mean a rectified sinusoid can reach maps to full scale. Both results are loaded together with a one-cycle valid pulse and then held. If the sample counter reaches its limit without a new rise, the block flags loss of line. It then waits for a fresh rise before it measures again.

Top module: `line_period_avg`

## Requirements
- R1: While reset is low, `freq_pu`, `avg_pu`, `out_vld` and `line_lost` are all zero.
- R2: A boundary is accepted only on a strobed sample with value >= `thr_hi` after an earlier strobed sample with value < `thr_lo`. The first boundary after reset or after a loss only starts the count and produces no result. A waveform that never falls below `thr_lo` produces no results.
- R3: A sample that falls below `thr_hi` but stays at or above `thr_lo`, followed by a sample back above `thr_hi`, does not start a new period.
- R4: `freq_pu` = floor(`n_min` * 32768 / N). When that value exceeds 32767 (N <= `n_min`), the output is 32767.
- R5: `avg_pu` = floor(S * 25736 / (N * 16384)), where S is the sum of the N samples from one boundary sample up to the sample before the next, and 25736 is pi/2 in Q14. Values above 32767 are clamped to 32767.
- R6: `out_vld` is a single-cycle pulse raised when a division completes. Every accepted boundary after the first gives exactly one pulse, as long as boundaries are spaced further apart than the division time.
- R7: `freq_pu` and `avg_pu` change only in a cycle where `out_vld` is high, and hold their value otherwise.
- R8: If a strobed sample arrives that is not a boundary while MAX_CNT samples have already been counted in the current period, `line_lost` goes high. No result is produced and the outputs keep their values. The next boundary only restarts counting, and `line_lost` clears with the next result.
- R9: A period of exactly MAX_CNT samples is measured normally and produces a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp | input | DW | Rectified line sample, unsigned Q15 |
| thr_hi | input | DW | Rising threshold that marks a boundary |
| thr_lo | input | DW | Re-arm threshold |
| n_min | input | CW | Sample count at the highest allowed rectified frequency |
| freq_pu | output | DW | Per-unit frequency, Q15 |
| avg_pu | output | DW | Period mean scaled by pi/2, Q15 |
| out_vld | output | 1 | One-cycle pulse when new results load |
| line_lost | output | 1 | Sample counter ran out without a boundary |

## Verification
The hardest state to reach from the ports is the count limit. It takes MAX_CNT + 1 strobed samples with no accepted rise, and after it the next rise must resync without producing a result. The bench builds the instance with a small MAX_CNT. It then feeds a long run of zero samples after a valid measurement and checks that the flag is set and the outputs are held. Next it replays the waveform and counts the results. A separate run uses a period of exactly MAX_CNT samples to pin down the edge of the limit. The hysteresis is tested with a sawtooth that dips once between the two thresholds just after its rise.

// File: rtl/line_period_avg.sv
module line_period_avg #(
  parameter int DW      = 15,
  parameter int MAX_CNT = 4095,
  parameter int PI2_Q14 = 25736,
  parameter int CW      = $clog2(MAX_CNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp,
  input  logic [DW-1:0] thr_hi,
  input  logic [DW-1:0] thr_lo,
  input  logic [CW-1:0] n_min,
  output logic [DW-1:0] freq_pu,
  output logic [DW-1:0] avg_pu,
  output logic          out_vld,
  output logic          line_lost
);

  localparam int SW   = DW + CW;
  localparam int NUMW = SW + 15;
  localparam int BW   = $clog2(NUMW);

  logic            armed, synced;
  logic [CW-1:0]   cnt;
  logic [SW-1:0]   acc;
  logic            busy;
  logic [BW-1:0]   step;
  logic [NUMW-1:0] na, nf, qa, qf;
  logic [CW-1:0]   ra, rf, den;

  wire fire = smp_vld && armed && (smp >= thr_hi);
  wire full = (cnt == CW'(MAX_CNT));

  wire [CW:0]      ta    = {ra, na[NUMW-1]};
  wire [CW:0]      tf    = {rf, nf[NUMW-1]};
  wire             ga    = ta >= {1'b0, den};
  wire             gf    = tf >= {1'b0, den};
  wire [CW:0]      da    = ta - {1'b0, den};
  wire [CW:0]      df    = tf - {1'b0, den};
  wire [CW-1:0]    ra_n  = ga ? da[CW-1:0] : ta[CW-1:0];
  wire [CW-1:0]    rf_n  = gf ? df[CW-1:0] : tf[CW-1:0];
  wire [NUMW-1:0]  qa_n  = {qa[NUMW-2:0], ga};
  wire [NUMW-1:0]  qf_n  = {qf[NUMW-2:0], gf};
  wire [DW-1:0]    f_sat = (|qf_n[NUMW-1:DW])    ? '1 : qf_n[DW-1:0];
  wire [DW-1:0]    a_sat = (|qa_n[NUMW-1:DW+14]) ? '1 : qa_n[DW+13:14];
  wire             last  = (step == BW'(NUMW - 1));
  wire             da_u  = da[CW] | df[CW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      synced    <= 1'b0;
      cnt       <= '0;
      acc       <= '0;
      busy      <= 1'b0;
      step      <= '0;
      na        <= '0;
      nf        <= '0;
      qa        <= '0;
      qf        <= '0;
      ra        <= '0;
      rf        <= '0;
      den       <= '0;
      freq_pu   <= '0;
      avg_pu    <= '0;
      out_vld   <= 1'b0;
      line_lost <= 1'b0;
    end else begin
      out_vld <= 1'b0;

      if (busy) begin
        na   <= na << 1;
        nf   <= nf << 1;
        ra   <= ra_n;
        rf   <= rf_n;
        qa   <= qa_n;
        qf   <= qf_n;
        step <= step + 1'b1;
        if (last) begin
          busy      <= 1'b0;
          out_vld   <= 1'b1;
          line_lost <= 1'b0;
          freq_pu   <= f_sat;
          avg_pu    <= a_sat;
        end
      end

      if (smp_vld) begin
        if (fire)
          armed <= 1'b0;
        else if (smp < thr_lo)
          armed <= 1'b1;

        if (fire) begin
          synced <= 1'b1;
          cnt    <= CW'(1);
          acc    <= SW'(smp);
          if (synced) begin
            na   <= NUMW'(acc) * NUMW'(PI2_Q14);
            nf   <= NUMW'(n_min) << DW;
            den  <= cnt;
            ra   <= '0;
            rf   <= '0;
            qa   <= '0;
            qf   <= '0;
            step <= '0;
            busy <= 1'b1;
          end
        end else if (synced) begin
          if (full) begin
            synced    <= 1'b0;
            line_lost <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
            acc <= acc + SW'(smp);
          end
        end
      end
    end
  end

  logic unused_ok;
  assign unused_ok = da_u;

endmodule

module line_period_avg_chk #(
  parameter int DW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld,
  input logic          out_vld,
  input logic          line_lost,
  input logic [DW-1:0] freq_pu,
  input logic [DW-1:0] avg_pu
);

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld); // R6

  AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(freq_pu)); // R7

  AST_AVG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(avg_pu)); // R7

  AST_LOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    line_lost |-> !out_vld); // R8

  AST_LOST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_lost) |-> $past(smp_vld)); // R8

endmodule

bind line_period_avg line_period_avg_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .out_vld(out_vld),
  .line_lost(line_lost), .freq_pu(freq_pu), .avg_pu(avg_pu)
);

// File: tb/test_line_period_avg.sv
`timescale 1ns/1ps
module test_line_period_avg;

  localparam int DW = 15;
  localparam int MC = 250;
  localparam int CW = $clog2(MC + 1);
  localparam int HI = 16000;
  localparam int LO = 4000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_vld = 1'b0;
  logic [DW-1:0] smp = '0;
  logic [DW-1:0] thr_hi = DW'(HI);
  logic [DW-1:0] thr_lo = DW'(LO);
  logic [CW-1:0] n_min = '0;
  logic [DW-1:0] freq_pu, avg_pu;
  logic          out_vld, line_lost;

  line_period_avg #(.DW(DW), .MAX_CNT(MC)) i_line_period_avg (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .n_min(n_min),
    .freq_pu(freq_pu), .avg_pu(avg_pu), .out_vld(out_vld), .line_lost(line_lost)
  );

  always #2.5 clk = ~clk;

  int     vec = 0, bad = 0, n_outs = 0, plen = 0, fidx = 0;
  int     wave [0:255];
  longint exp_f = 0, exp_a = 0, last_f = 0, last_a = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint ex);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, ex);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      n_outs++;
      chk(freq_pu == DW'(exp_f), "R4 freq", freq_pu, exp_f);
      chk(avg_pu == DW'(exp_a), "R5 avg", avg_pu, exp_a);
      last_f = freq_pu;
      last_a = avg_pu;
    end
  end

  task automatic build_saw(input int p, input bit bounce, input int base);
    plen = p;
    fidx = -1;
    for (int i = 0; i < p; i++) begin
      wave[i] = base + (i * (32000 - base)) / (p - 1);
      if (fidx < 0 && wave[i] >= HI) fidx = i;
    end
    if (bounce) wave[fidx + 1] = HI - 100;
  endtask

  task automatic build_square(input int p);
    plen = p;
    wave[0] = 0;
    for (int i = 1; i < p; i++) wave[i] = 32767;
    fidx = 1;
  endtask

  task automatic set_exp(input int nm);
    longint s = 0;
    for (int i = 0; i < plen; i++) s += wave[i];
    n_min = CW'(nm);
    exp_f = (longint'(nm) * 32768) / plen;
    if (exp_f > 32767) exp_f = 32767;
    exp_a = (s * 25736) / (longint'(plen) * 16384);
    if (exp_a > 32767) exp_a = 32767;
  endtask

  task automatic put(input int v);
    @(negedge clk);
    smp_vld = 1'b1;
    smp = DW'(v);
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(freq_pu == 0 && avg_pu == 0 && !out_vld && !line_lost, "R1 reset", freq_pu + avg_pu, 0);
    rst_n = 1'b1;
    n_outs = 0;
  endtask

  task automatic drive(input int nper);
    for (int k = 0; k < nper; k++)
      for (int i = 0; i < plen; i++) put(wave[i]);
    for (int i = 0; i <= fidx; i++) put(wave[i]);
    repeat (100) @(negedge clk);
  endtask

  task automatic run(input int nper, input int nm, input string tag);
    set_exp(nm);
    do_reset();
    drive(nper);
    chk(n_outs == nper, tag, n_outs, nper);
    chk(freq_pu == DW'(last_f) && avg_pu == DW'(last_a), "R7 hold", freq_pu, last_f);
  endtask

  initial begin
    #750us;
    bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    // R4 R5 R6: period sweep across the counter range
    for (int p = 20; p <= 245; p += 9) begin
      build_saw(p, 1'b0, 0);
      run(2, 20, "R6 count sweep");
    end
    // R4: n_min sweep at a fixed period, crossing saturation at N <= n_min
    for (int nm = 1; nm <= 250; nm += 13) begin
      build_saw(100, 1'b0, 0);
      run(2, nm, "R4 nmin sweep");
    end
    build_saw(100, 1'b0, 0);
    run(2, 100, "R4 N equals nmin");
    // R9: period exactly at the counter limit
    build_saw(MC, 1'b0, 0);
    run(2, 200, "R9 max period");
    // R3: dip between thresholds after the rise
    for (int p = 40; p <= 160; p += 30) begin
      build_saw(p, 1'b1, 0);
      run(3, 50, "R3 hysteresis");
    end
    // R5: mean clamps at full scale
    build_square(40);
    run(2, 30, "R5 saturate");
    // R2: never re-armed, no results
    build_saw(60, 1'b0, 5000);
    set_exp(40);
    do_reset();
    drive(3);
    chk(n_outs == 0, "R2 no arm", n_outs, 0);
    // R8: loss of line and resync
    build_saw(60, 1'b0, 0);
    set_exp(40);
    do_reset();
    drive(1);
    chk(n_outs == 1, "R2 first sync only", n_outs, 1);
    for (int i = 0; i < 260; i++) put(0);
    repeat (100) @(negedge clk);
    chk(line_lost == 1'b1, "R8 flag", line_lost, 1);
    chk(n_outs == 1, "R8 no result", n_outs, 1);
    chk(freq_pu == DW'(exp_f), "R8 held", freq_pu, exp_f);
    drive(2);
    chk(n_outs == 3, "R8 resync count", n_outs, 3);
    chk(line_lost == 1'b0, "R8 clear", line_lost, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule